// File: doc/BRIEF.md
# Arbitrated Guarded Memory Controller

This block sits in front of one word-addressed storage array and shares it between three masters: a ground-support DMA port, a command/data-handling DMA port and the processor. It also serves an internal heartbeat writer and an internal background checksum walker. Every cycle, at most one of these is given the array. Ports that win the array perform a single word read or write in that cycle. Read data is returned one cycle later on a shared read bus. A discrete input clamps the processor's requests off, and the two DMA ports keep full service during the clamp. A second discrete picks which of two storage copies (primary or secondary) all traffic uses.

Writes are fenced by a hardware protect register that holds one bit per address region. Software cannot open it alone. A new protect value takes effect only while an unlock discrete is high and the command carries a key equal to the bitwise complement of the value. Nothing in the block holds a key. The array has no parity. Instead, the checksum walker uses cycles that no one else claims to add up every word of the selected copy and compares the total against an externally held reference. The heartbeat writer deposits a rising sequence number at a fixed address at a fixed interval, on behalf of the command/data-handling side.

Top module: `guarded_mem_ctrl`

## Requirements
- R1: Each cycle at most one access is granted. Grants are combinational on the current requests, with this fixed order: ground DMA, then command/data DMA, then a pending heartbeat, then the processor. The checksum walker gets only cycles in which none of these is granted. A requester whose grant is high completes its access in that cycle.
- R2: While `cpu_hold` is 1, `cpu_gnt` stays 0 whatever `cpu_req` is, and both DMA ports are granted and served exactly as when the hold is 0.
- R3: A granted read (`*_we` = 0) raises `rd_vld` for exactly the next cycle, with `rd_data` equal to the addressed word of the selected copy. Writes and idle cycles leave `rd_vld` at 0.
- R4: `bank_sel` = 0 routes every access and the checksum walk to copy 0, and 1 routes them to copy 1. The other copy is untouched. Any change of `bank_sel` restarts the checksum pass at word 0 with a zero sum, and the pass makes no progress in the cycle of the change.
- R5: The region of an address is its top log2(NREG) bits (default: addr[5:3], eight words per region). A granted write, heartbeat writes included, whose region bit in `prot_state` is 1 leaves the array unchanged and sets `wr_viol`. `wr_viol` stays 1 until reset.
- R6: `prot_state` takes `prot_val` at the clock edge only when `prot_wr`, `unlock` and `prot_key == ~prot_val` are all true in that cycle. Otherwise it holds its value.
- R7: A heartbeat becomes pending one cycle after every HB_PERIOD-th cycle since reset (default 32, first pending in cycle 32). The n-th granted heartbeat writes the value n to address HB_ADDR (default 63). The pending state clears when it is granted.
- R8: In every cycle it is given, the walker adds the word at its pointer to a CSW-bit modular sum and advances the pointer by one, starting from address 0. On the cycle that consumes the last address, `cs_done` pulses for one cycle on the next edge, `cs_err` pulses with it when the final sum differs from `cs_ref`, and a new pass begins from 0.
- R9: After reset, no grant is given without a request. `rd_vld`, `wr_viol`, `cs_done` and `cs_err` are 0, `prot_state` is all zero, and both copies hold all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Copy select discrete: 0 primary, 1 secondary |
| cpu_hold | input | 1 | Discrete that clamps processor requests off |
| gs_req | input | 1 | Ground DMA request |
| gs_we | input | 1 | Ground DMA write enable |
| gs_addr | input | AW | Ground DMA word address |
| gs_wdata | input | DW | Ground DMA write data |
| gs_gnt | output | 1 | Ground DMA grant |
| cd_req | input | 1 | Command/data DMA request |
| cd_we | input | 1 | Command/data DMA write enable |
| cd_addr | input | AW | Command/data DMA word address |
| cd_wdata | input | DW | Command/data DMA write data |
| cd_gnt | output | 1 | Command/data DMA grant |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor grant |
| rd_data | output | DW | Read data of the previous cycle's granted read |
| rd_vld | output | 1 | rd_data is valid |
| unlock | input | 1 | Discrete that permits protect updates |
| prot_wr | input | 1 | Protect update command strobe |
| prot_val | input | NREG | New protect bits, one per region |
| prot_key | input | NREG | Key that must equal the complement of prot_val |
| prot_state | output | NREG | Current protect bits |
| wr_viol | output | 1 | Sticky flag for a write dropped by protection |
| cs_ref | input | CSW | Reference checksum |
| cs_done | output | 1 | One-cycle pulse at the end of each checksum pass |
| cs_err | output | 1 | One-cycle pulse when a finished pass mismatches cs_ref |

## Verification
The bench tries arbitration with single uncontended accesses, then with all three ports asking in the same cycle, which shows whether the fixed order holds. It also runs with the processor clamped while the DMA ports work, which separates masking of the processor from a general stall. Protection is exercised with a missing unlock, a wrong key and a correct key, followed by writes into guarded and open regions and a read-back. This separates an ignored command from a dropped write. The checksum is observed on an all-zero array, on a filled array whose reference matches and does not match, and across copy switches, which separates restart behaviour from ordinary wrap-around. Heartbeat writes interleaving with DMA traffic show whether the pending slot waits correctly behind the ports.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
   // Source that owns the array in a cycle.
   typedef enum logic [2:0] {
      SRC_IDLE = 3'd0,
      SRC_GS   = 3'd1,
      SRC_CD   = 3'd2,
      SRC_HB   = 3'd3,
      SRC_CPU  = 3'd4
   } src_e;
endpackage

// File: rtl/gmc_arbiter.sv
module gmc_arbiter
   import gmc_pkg::*;
(
   input  logic gs_req,
   input  logic cd_req,
   input  logic hb_pend,
   input  logic cpu_req,
   input  logic cpu_hold,
   output logic gs_gnt,
   output logic cd_gnt,
   output logic hb_gnt,
   output logic cpu_gnt,
   output logic idle,
   output src_e src
);
   logic cpu_eff;

   assign cpu_eff = cpu_req & ~cpu_hold;

   always_comb begin
      gs_gnt  = 1'b0;
      cd_gnt  = 1'b0;
      hb_gnt  = 1'b0;
      cpu_gnt = 1'b0;
      src     = SRC_IDLE;
      if (gs_req) begin
         gs_gnt = 1'b1;
         src    = SRC_GS;
      end else if (cd_req) begin
         cd_gnt = 1'b1;
         src    = SRC_CD;
      end else if (hb_pend) begin
         hb_gnt = 1'b1;
         src    = SRC_HB;
      end else if (cpu_eff) begin
         cpu_gnt = 1'b1;
         src     = SRC_CPU;
      end
   end

   assign idle = (src == SRC_IDLE);
endmodule

// File: rtl/gmc_protect.sv
module gmc_protect #(
   parameter int AW   = 6,
   parameter int NREG = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            unlock,
   input  logic            prot_wr,
   input  logic [NREG-1:0] prot_val,
   input  logic [NREG-1:0] prot_key,
   input  logic            wr_req,
   input  logic [AW-1:0]   wr_addr,
   output logic            wr_ok,
   output logic [NREG-1:0] prot_state,
   output logic            wr_viol
);
   localparam int RB = $clog2(NREG);

   logic [RB-1:0] region;
   logic          hit;
   logic          key_good;

   assign region   = wr_addr[AW-1 -: RB];
   assign hit      = prot_state[region];
   assign wr_ok    = wr_req & ~hit;
   assign key_good = (prot_key == ~prot_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_state <= '0;
         wr_viol    <= 1'b0;
      end else begin
         if (prot_wr && unlock && key_good)
            prot_state <= prot_val;
         if (wr_req && hit)
            wr_viol <= 1'b1;
      end
   end
endmodule

// File: rtl/gmc_store.sv
module gmc_store #(
   parameter int AW    = 6,
   parameter int DW    = 16,
   parameter int NCOPY = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NCOPY)-1:0] bank,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [AW-1:0]            raddr_a,
   output logic [DW-1:0]            rdata_a,
   input  logic [AW-1:0]            raddr_b,
   output logic [DW-1:0]            rdata_b
);
   localparam int DEPTH = 1 << AW;
   localparam int BKW   = $clog2(NCOPY);

   logic [DW-1:0] rda [NCOPY];
   logic [DW-1:0] rdb [NCOPY];

   for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we && (bank == BKW'(c))) begin
            mem[waddr] <= wdata;
         end
      end

      assign rda[c] = mem[raddr_a];
      assign rdb[c] = mem[raddr_b];
   end

   assign rdata_a = rda[bank];
   assign rdata_b = rdb[bank];
endmodule

// File: rtl/gmc_cksum.sv
module gmc_cksum #(
   parameter int AW  = 6,
   parameter int DW  = 16,
   parameter int CSW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bank_sel,
   input  logic           idle,
   input  logic [DW-1:0]  word,
   input  logic [CSW-1:0] cs_ref,
   output logic [AW-1:0]  ptr,
   output logic           cs_done,
   output logic           cs_err
);
   logic [CSW-1:0] sum;
   logic [CSW-1:0] sum_nx;
   logic           bank_q;

   assign sum_nx = sum + word[CSW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         sum     <= '0;
         bank_q  <= 1'b0;
         cs_done <= 1'b0;
         cs_err  <= 1'b0;
      end else begin
         cs_done <= 1'b0;
         cs_err  <= 1'b0;
         bank_q  <= bank_sel;
         if (bank_sel != bank_q) begin
            ptr <= '0;
            sum <= '0;
         end else if (idle) begin
            if (&ptr) begin
               cs_done <= 1'b1;
               cs_err  <= (sum_nx != cs_ref);
               sum     <= '0;
               ptr     <= '0;
            end else begin
               sum <= sum_nx;
               ptr <= ptr + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/guarded_mem_ctrl.sv
module guarded_mem_ctrl
   import gmc_pkg::*;
#(
   parameter int AW        = 6,
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int CSW       = 16,
   parameter int HB_PERIOD = 32,
   parameter int HB_ADDR   = 63
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bank_sel,
   input  logic            cpu_hold,
   input  logic            gs_req,
   input  logic            gs_we,
   input  logic [AW-1:0]   gs_addr,
   input  logic [DW-1:0]   gs_wdata,
   output logic            gs_gnt,
   input  logic            cd_req,
   input  logic            cd_we,
   input  logic [AW-1:0]   cd_addr,
   input  logic [DW-1:0]   cd_wdata,
   output logic            cd_gnt,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic            cpu_gnt,
   output logic [DW-1:0]   rd_data,
   output logic            rd_vld,
   input  logic            unlock,
   input  logic            prot_wr,
   input  logic [NREG-1:0] prot_val,
   input  logic [NREG-1:0] prot_key,
   output logic [NREG-1:0] prot_state,
   output logic            wr_viol,
   input  logic [CSW-1:0]  cs_ref,
   output logic            cs_done,
   output logic            cs_err
);
   localparam int DEPTH = 1 << AW;
   localparam int TW    = $clog2(HB_PERIOD);
   localparam int NCOPY = 2;

   if (HB_ADDR < 0 || HB_ADDR >= DEPTH) begin : g_bad_hb_addr
      $error("HB_ADDR outside the array");
   end
   if (NREG < 2 || (1 << $clog2(NREG)) != NREG || NREG > DEPTH) begin : g_bad_nreg
      $error("NREG must be a power of two between 2 and the depth");
   end
   if (CSW > DW || CSW < 1) begin : g_bad_csw
      $error("CSW must lie between 1 and DW");
   end
   if (HB_PERIOD < 2) begin : g_bad_period
      $error("HB_PERIOD must be at least 2");
   end

   logic          hb_pend, hb_gnt, idle;
   logic [TW-1:0] hb_tick;
   logic [DW-1:0] hb_seq;
   src_e          src;

   logic          acc_any, acc_we, wr_ok;
   logic [AW-1:0] acc_addr, cs_ptr;
   logic [DW-1:0] acc_wdata, rdata_a, rdata_b;

   gmc_arbiter u_arb (
      .gs_req  (gs_req),
      .cd_req  (cd_req),
      .hb_pend (hb_pend),
      .cpu_req (cpu_req),
      .cpu_hold(cpu_hold),
      .gs_gnt  (gs_gnt),
      .cd_gnt  (cd_gnt),
      .hb_gnt  (hb_gnt),
      .cpu_gnt (cpu_gnt),
      .idle    (idle),
      .src     (src)
   );

   always_comb begin
      acc_any   = 1'b1;
      acc_we    = 1'b0;
      acc_addr  = '0;
      acc_wdata = '0;
      case (src)
         SRC_GS: begin
            acc_we = gs_we;  acc_addr = gs_addr;  acc_wdata = gs_wdata;
         end
         SRC_CD: begin
            acc_we = cd_we;  acc_addr = cd_addr;  acc_wdata = cd_wdata;
         end
         SRC_HB: begin
            acc_we = 1'b1;  acc_addr = AW'(HB_ADDR);  acc_wdata = hb_seq + 1'b1;
         end
         SRC_CPU: begin
            acc_we = cpu_we;  acc_addr = cpu_addr;  acc_wdata = cpu_wdata;
         end
         default: acc_any = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_tick <= '0;
         hb_pend <= 1'b0;
         hb_seq  <= '0;
      end else begin
         hb_tick <= (hb_tick == TW'(HB_PERIOD - 1)) ? '0 : hb_tick + 1'b1;
         hb_pend <= (hb_tick == TW'(HB_PERIOD - 1)) | (hb_pend & ~hb_gnt);
         if (hb_gnt) hb_seq <= hb_seq + 1'b1;
      end
   end

   gmc_protect #(.AW(AW), .NREG(NREG)) u_prot (
      .clk       (clk),
      .rst_n     (rst_n),
      .unlock    (unlock),
      .prot_wr   (prot_wr),
      .prot_val  (prot_val),
      .prot_key  (prot_key),
      .wr_req    (acc_any & acc_we),
      .wr_addr   (acc_addr),
      .wr_ok     (wr_ok),
      .prot_state(prot_state),
      .wr_viol   (wr_viol)
   );

   gmc_store #(.AW(AW), .DW(DW), .NCOPY(NCOPY)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .bank   (bank_sel),
      .we     (wr_ok),
      .waddr  (acc_addr),
      .wdata  (acc_wdata),
      .raddr_a(acc_addr),
      .rdata_a(rdata_a),
      .raddr_b(cs_ptr),
      .rdata_b(rdata_b)
   );

   gmc_cksum #(.AW(AW), .DW(DW), .CSW(CSW)) u_cks (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_sel(bank_sel),
      .idle    (idle),
      .word    (rdata_b),
      .cs_ref  (cs_ref),
      .ptr     (cs_ptr),
      .cs_done (cs_done),
      .cs_err  (cs_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= acc_any & ~acc_we;
         if (acc_any && !acc_we) rd_data <= rdata_a;
      end
   end
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
   parameter int NREG = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            gs_req,
   input logic            cd_req,
   input logic            cpu_hold,
   input logic            gs_gnt,
   input logic            cd_gnt,
   input logic            cpu_gnt,
   input logic            unlock,
   input logic            wr_viol,
   input logic            cs_done,
   input logic            cs_err,
   input logic [NREG-1:0] prot_state
);
   p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gs_gnt, cd_gnt, cpu_gnt}));

   p_ground_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gs_req |-> (gs_gnt && !cd_gnt && !cpu_gnt));

   p_cd_second_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_req && !gs_req) |-> (cd_gnt && !cpu_gnt));

   p_cpu_clamped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold |-> !cpu_gnt);

   p_viol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_viol |=> wr_viol);

   p_prot_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !unlock |=> $stable(prot_state));

   p_err_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_err |-> cs_done);
endmodule

bind guarded_mem_ctrl gmc_checker #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gs_req    (gs_req),
   .cd_req    (cd_req),
   .cpu_hold  (cpu_hold),
   .gs_gnt    (gs_gnt),
   .cd_gnt    (cd_gnt),
   .cpu_gnt   (cpu_gnt),
   .unlock    (unlock),
   .wr_viol   (wr_viol),
   .cs_done   (cs_done),
   .cs_err    (cs_err),
   .prot_state(prot_state)
);

// File: tb/sim_guarded_mem_ctrl.sv
`timescale 1ns/1ps
module sim_guarded_mem_ctrl;
   localparam int AW = 6, DW = 16, NREG = 8, CSW = 16;
   localparam int DEPTH = 64, HBP = 32, HBA = 63;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bank_sel = 0, cpu_hold = 0;
   logic gs_req = 0, gs_we = 0, cd_req = 0, cd_we = 0, cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] gs_addr = '0, cd_addr = '0, cpu_addr = '0;
   logic [DW-1:0] gs_wdata = '0, cd_wdata = '0, cpu_wdata = '0;
   logic gs_gnt, cd_gnt, cpu_gnt, rd_vld, wr_viol, cs_done, cs_err;
   logic [DW-1:0] rd_data;
   logic unlock = 0, prot_wr = 0;
   logic [NREG-1:0] prot_val = '0, prot_key = '0, prot_state;
   logic [CSW-1:0] cs_ref = '0;

   always #2.5 clk = ~clk;

   guarded_mem_ctrl u0 (.*);

   int n_cmp = 0, n_bad = 0, cyc = 0;
   string rd_tag = "R3";

   // behavioural reference state
   logic [15:0] m_mem [2][DEPTH];
   logic [7:0]  m_prot = 0;
   bit          m_viol = 0, m_pend = 0, m_bankq = 0, m_rdv = 0, m_done = 0, m_err = 0;
   int          m_tick = 0, m_seq = 0, m_ptr = 0;
   logic [15:0] m_sum = 0, m_rdd = 0;
   bit          last_g [3];

   always @(posedge clk) cyc++;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      bit g_gs, g_cd, g_hb, g_cpu, idle, any, w;
      int a, b, reg_i;
      logic [15:0] d, word;
      #1;
      g_gs  = gs_req;
      g_cd  = cd_req && !gs_req;
      g_hb  = m_pend && !gs_req && !cd_req;
      g_cpu = cpu_req && !cpu_hold && !gs_req && !cd_req && !m_pend;
      any   = g_gs || g_cd || g_hb || g_cpu;
      idle  = !any;
      chk("R1 gs_gnt", gs_gnt, g_gs);
      chk("R1 cd_gnt", cd_gnt, g_cd);
      chk(cpu_hold ? "R2 cpu_gnt under hold" : "R1 cpu_gnt", cpu_gnt, g_cpu);
      last_g[0] = g_gs; last_g[1] = g_cd; last_g[2] = g_cpu;
      b = bank_sel; w = 0; a = 0; d = 0;
      if (g_gs)       begin w = gs_we;  a = gs_addr;  d = gs_wdata;  end
      else if (g_cd)  begin w = cd_we;  a = cd_addr;  d = cd_wdata;  end
      else if (g_hb)  begin w = 1;      a = HBA;      d = 16'(m_seq + 1); end
      else if (g_cpu) begin w = cpu_we; a = cpu_addr; d = cpu_wdata; end
      m_rdv = any && !w;
      if (m_rdv) m_rdd = m_mem[b][a];
      reg_i = a / (DEPTH / NREG);
      if (any && w) begin
         if (m_prot[reg_i]) m_viol = 1;
         else m_mem[b][a] = d;
      end
      if (prot_wr && unlock && (prot_key == ~prot_val)) m_prot = prot_val;
      if (g_hb) m_seq++;
      m_pend = (m_tick == HBP - 1) || (m_pend && !g_hb);
      m_tick = (m_tick == HBP - 1) ? 0 : m_tick + 1;
      m_done = 0; m_err = 0;
      if (b != int'(m_bankq)) begin
         m_ptr = 0; m_sum = 0;
      end else if (idle) begin
         word = m_mem[b][m_ptr];
         if (m_ptr == DEPTH - 1) begin
            m_done = 1;
            m_err  = (16'(m_sum + word) != cs_ref);
            m_ptr = 0; m_sum = 0;
         end else begin
            m_sum = m_sum + word;
            m_ptr++;
         end
      end
      m_bankq = b[0];
      @(posedge clk);
      #1;
      chk("R3 rd_vld", rd_vld, m_rdv);
      if (m_rdv) chk({rd_tag, " rd_data"}, rd_data, m_rdd);
      chk("R6 prot_state", prot_state, m_prot);
      chk("R5 wr_viol", wr_viol, m_viol);
      chk("R8 cs_done", cs_done, m_done);
      chk("R8 cs_err", cs_err, m_err);
      @(negedge clk);
   endtask

   task automatic xfer(input int port, input bit we, input int addr, input logic [15:0] data);
      int n = 0;
      case (port)
         0: begin gs_req = 1; gs_we = we; gs_addr = AW'(addr); gs_wdata = data; end
         1: begin cd_req = 1; cd_we = we; cd_addr = AW'(addr); cd_wdata = data; end
         default: begin cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = data; end
      endcase
      do begin step(); n++; end while (!last_g[port] && n < 300);
      gs_req = 0; cd_req = 0; cpu_req = 0;
   endtask

   task automatic idle_run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      wait (cyc > 20000);
      n_bad++;
      $display("FAIL watchdog expired, run hung");
      summary();
   end

   initial begin : main
      logic [15:0] s;
      int n;
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < DEPTH; i++) m_mem[c][i] = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 gs_gnt", gs_gnt, 0);
      chk("R9 cd_gnt", cd_gnt, 0);
      chk("R9 cpu_gnt", cpu_gnt, 0);
      chk("R9 rd_vld", rd_vld, 0);
      chk("R9 prot_state", prot_state, 0);
      chk("R9 wr_viol", wr_viol, 0);
      chk("R9 cs_done", cs_done, 0);
      chk("R9 cs_err", cs_err, 0);
      rst_n = 1;

      // R8 / R7: idle array, passes with heartbeats landing
      idle_run(140);
      rd_tag = "R7";
      xfer(0, 0, HBA, 0);

      // R3: fill copy 0 and read back through each port
      rd_tag = "R3";
      for (int i = 0; i < DEPTH; i++) xfer(0, 1, i, 16'(i * 37 + 5));
      xfer(1, 0, 7, 0);
      xfer(2, 0, 33, 0);
      xfer(0, 0, 50, 0);
      xfer(2, 1, 34, 16'hBEEF);
      xfer(1, 0, 34, 0);

      // R1: all three ports request in the same cycle
      rd_tag = "R1";
      gs_req = 1; gs_we = 0; gs_addr = 1;
      cd_req = 1; cd_we = 0; cd_addr = 2;
      cpu_req = 1; cpu_we = 0; cpu_addr = 3;
      n = 0;
      while ((gs_req || cd_req || cpu_req) && n < 50) begin
         step(); n++;
         if (last_g[0]) gs_req = 0;
         if (last_g[1]) cd_req = 0;
         if (last_g[2]) cpu_req = 0;
      end

      // R2: processor clamped while both DMA ports work
      rd_tag = "R2";
      cpu_hold = 1;
      cpu_req = 1; cpu_we = 1; cpu_addr = 5; cpu_wdata = 16'h5555;
      idle_run(4);
      cd_req = 1; cd_we = 1; cd_addr = 9; cd_wdata = 16'h0909; step(); cd_req = 0;
      gs_req = 1; gs_we = 0; gs_addr = 9; step(); gs_req = 0;
      idle_run(3);
      cpu_hold = 0;
      n = 0;
      do begin step(); n++; end while (!last_g[2] && n < 50);
      cpu_req = 0;
      xfer(1, 0, 5, 0);

      // R6: protect updates
      prot_wr = 1; prot_val = 8'h81; prot_key = ~8'h81; unlock = 0;
      step();
      unlock = 1; prot_key = 8'h81;
      step();
      prot_key = ~8'h81;
      step();
      prot_wr = 0; unlock = 0; prot_val = 8'hFF; prot_key = 8'h00;
      step();

      // R5: guarded and open regions
      rd_tag = "R5";
      xfer(0, 1, 2, 16'hDEAD);
      xfer(0, 0, 2, 0);
      xfer(2, 1, 20, 16'h2020);
      xfer(2, 0, 20, 0);
      idle_run(40);
      rd_tag = "R7";
      xfer(1, 0, HBA, 0);

      // R4: secondary copy
      rd_tag = "R4";
      bank_sel = 1;
      idle_run(5);
      xfer(0, 1, 10, 16'h1234);
      xfer(0, 0, 10, 0);
      xfer(0, 0, 11, 0);
      bank_sel = 0;
      step();
      xfer(0, 0, 10, 0);

      // R8: matching reference, bank hop mid-pass, then wrong reference
      rd_tag = "R8";
      s = 0;
      for (int i = 0; i < DEPTH; i++) s = s + m_mem[0][i];
      cs_ref = s;
      idle_run(150);
      bank_sel = 1; idle_run(20); bank_sel = 0;
      idle_run(150);
      cs_ref = s ^ 16'h0001;
      idle_run(150);

      summary();
   end
endmodule